// File: doc/BRIEF.md
# Sparse Boundary Carry Tree

This block supplies the carries that the byte-wide sum sections of a wide adder need. It takes the per-bit generate and propagate terms of a 56-bit addition and the adder's carry-in. It returns the carry into every bit position that is a multiple of eight, from bit 0 up to the carry-out at bit 56. Per-bit carries inside a byte are not formed. A downstream carry-select stage would pick between its precomputed byte sums with these carries.

The carries come from a single upward pass of three levels. Each node merges at most four (generate, propagate) pairs with the usual prefix combine: `G = Gh | (Ph & Gl)`, `P = Ph & Pl`. Level one builds 4-bit spans. Level two builds one 16-bit span for each byte boundary, and neighbouring spans overlap by a byte. Level three joins up to four of these spans, with the carry-in as an extra low operand where there is room, to give each boundary carry. There is no downward fill-in pass. The block is combinational, so the carries follow the inputs in the same cycle.

Top module: `cst_carry_tree`

## Requirements
- R1: `carry_o[0]` equals `cin_i` for every input pattern.
- R2: For m = 1..7, `carry_o[m]` equals bit 8m of `A[8m-1:0] + B[8m-1:0] + cin_i` whenever `gen_i = A & B` and `prop_i = A ^ B`.
- R3: `carry_o[7]` is the carry out of the full 56-bit sum `A + B + cin_i`.
- R4: When every bit of byte m (bits 8m..8m+7) propagates and none generates, `carry_o[m+1]` equals `carry_o[m]`. An all-propagate word therefore passes `cin_i` to every output bit.
- R5: With `gen_i` and `prop_i` both all zero, `carry_o[7:1]` is zero whatever `cin_i` is.
- R6: A generate at bit 8m-1 forces `carry_o[m]` to 1.
- R7: A kill at bit 8m-1 (generate and propagate both 0) forces `carry_o[m]` to 0, whatever happens at lower bits.
- R8: The block holds no state. Every output is valid in the same cycle as the inputs that produce it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gen_i | input | 56 | Per-bit generate terms, bit i = A[i] & B[i] |
| prop_i | input | 56 | Per-bit propagate terms, bit i = A[i] ^ B[i] |
| cin_i | input | 1 | Carry into bit 0 |
| carry_o | output | 8 | Bit m is the carry into bit 8m; bit 7 is the carry-out |

## Verification
Every carry output is combinational, so each result is due in the same cycle as the operand that causes it, with no register on the path. The bench applies each new operand pair just after a rising clock edge and reads `carry_o` at the next falling edge. This gives the logic half a period to settle, and no read races with the drive. Expected carries come from a plain integer sum of the masked operands, taken at each byte boundary.

// File: rtl/cst_pkg.sv
package cst_pkg;

  // Generate/propagate pair describing one bit range
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  // Prefix combine of an upper range with the range just below it
  // (or overlapping it; the operator is idempotent)
  function automatic gp_t gp_join(input gp_t hi, input gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/cst_merge.sv
module cst_merge
  import cst_pkg::*;
#(
  parameter int N = 4
) (
  input  gp_t [N-1:0] ops_i,   // index 0 is the least significant range
  output gp_t         span_o
);

  // Serial chain from the low operand upward, like a short carry chain
  always_comb begin
    gp_t acc;
    acc = ops_i[0];
    for (int i = 1; i < N; i++) begin
      acc = gp_join(ops_i[i], acc);
    end
    span_o = acc;
  end

endmodule

// File: rtl/cst_boundary_node.sv
module cst_boundary_node
  import cst_pkg::*;
#(
  parameter int NGRP = 7,
  parameter int J    = 1        // boundary index: carry into bit 8*J
) (
  input  gp_t [NGRP:1] span_i,  // 16-bit spans ending at each byte boundary
  input  gp_t          cin_i,
  output logic         carry_o
);

  // Odd J: spans J, J-2, .., 1 (span 1 already holds the carry-in).
  // Even J: spans J, J-2, .., 2 plus the carry-in as lowest operand.
  localparam bit ODD_J = (J % 2) == 1;
  localparam int NOPS  = ODD_J ? (J + 1) / 2 : J / 2 + 1;

  gp_t [NOPS-1:0] ops;
  gp_t            span;

  generate
    if (ODD_J) begin : g_odd
      for (genvar t = 0; t < NOPS; t++) begin : g_op
        assign ops[t] = span_i[1 + 2 * t];
      end
    end else begin : g_even
      assign ops[0] = cin_i;
      for (genvar t = 1; t < NOPS; t++) begin : g_op
        assign ops[t] = span_i[2 * t];
      end
    end
  endgenerate

  cst_merge #(.N(NOPS)) u_merge (
    .ops_i  (ops),
    .span_o (span)
  );

  assign carry_o = span.g;

endmodule

// File: rtl/cst_carry_tree.sv
module cst_carry_tree
  import cst_pkg::*;
#(
  parameter int WIDTH = 56,     // multiple of 8, at most 64
  parameter int RADIX = 4
) (
  input  logic [WIDTH-1:0]       gen_i,
  input  logic [WIDTH-1:0]       prop_i,
  input  logic                   cin_i,
  output logic [WIDTH/8:0]       carry_o
);

  localparam int GROUP = 2 * RADIX;          // byte group width
  localparam int NNIB  = WIDTH / RADIX;      // level-one spans
  localparam int NGRP  = WIDTH / GROUP;      // boundaries above bit 0

  gp_t [WIDTH-1:0] bits;
  gp_t [NNIB-1:0]  nib;
  gp_t [NGRP:1]    span16;
  gp_t             cin_gp;

  assign cin_gp = '{g: cin_i, p: 1'b0};

  // Level 0: pack per-bit terms
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign bits[i] = '{g: gen_i[i], p: prop_i[i]};
    end
  endgenerate

  // Level 1: 4-bit spans
  generate
    for (genvar n = 0; n < NNIB; n++) begin : g_l1
      cst_merge #(.N(RADIX)) u_l1 (
        .ops_i  (bits[RADIX*n +: RADIX]),
        .span_o (nib[n])
      );
    end
  endgenerate

  // Level 2: 16-bit span ending at each byte boundary; neighbours overlap
  generate
    for (genvar j = 1; j <= NGRP; j++) begin : g_l2
      if (j == 1) begin : g_low
        cst_merge #(.N(3)) u_l2 (
          .ops_i  ({nib[1], nib[0], cin_gp}),
          .span_o (span16[j])
        );
      end else begin : g_mid
        cst_merge #(.N(RADIX)) u_l2 (
          .ops_i  (nib[2*j-1 -: RADIX]),
          .span_o (span16[j])
        );
      end
    end
  endgenerate

  // Level 3: one node per boundary
  assign carry_o[0] = cin_i;
  generate
    for (genvar j = 1; j <= NGRP; j++) begin : g_l3
      cst_boundary_node #(.NGRP(NGRP), .J(j)) u_node (
        .span_i  (span16),
        .cin_i   (cin_gp),
        .carry_o (carry_o[j])
      );
    end
  endgenerate

  // Checks at each boundary
  generate
    for (genvar k = 1; k <= NGRP; k++) begin : g_chk
      always_comb begin
        if (gen_i[GROUP*k-1]) begin
          p_gen_forces_r6: assert (carry_o[k] == 1'b1)
            else $error("R6: generate below boundary %0d not seen", k);
        end
        if (!gen_i[GROUP*k-1] && !prop_i[GROUP*k-1]) begin
          p_kill_clears_r7: assert (carry_o[k] == 1'b0)
            else $error("R7: kill below boundary %0d not honoured", k);
        end
        if ((&prop_i[GROUP*(k-1) +: GROUP]) && !(|gen_i[GROUP*(k-1) +: GROUP])) begin
          p_byte_pass_r4: assert (carry_o[k] == carry_o[k-1])
            else $error("R4: propagating byte %0d altered carry", k-1);
        end
      end
    end
  endgenerate

  always_comb begin
    if (gen_i == '0 && prop_i == '0) begin
      p_zero_word_r5: assert (carry_o[NGRP:1] == '0)
        else $error("R5: zero operands produced a carry");
    end
  end

endmodule

// File: tb/cst_carry_tree_tb.sv
module cst_carry_tree_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 56;
  localparam int NB = W / 8;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         cin;
    logic [NB:0]  exp;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{56'h0,                 56'h0,                 1'b0, 8'h00},
    '{56'h0,                 56'h0,                 1'b1, 8'h01},
    '{56'hFF_FFFF_FFFF_FFFF, 56'h0,                 1'b1, 8'hFF},
    '{56'hFF_FFFF_FFFF_FFFF, 56'h0,                 1'b0, 8'h00},
    '{56'hFF_FFFF_FFFF_FFFF, 56'hFF_FFFF_FFFF_FFFF, 1'b0, 8'hFE},
    '{56'h80,                56'h80,                1'b0, 8'h02},
    '{56'h80_0000_0000_0000, 56'h80_0000_0000_0000, 1'b0, 8'h80},
    '{56'hFFFF,              56'h1,                 1'b0, 8'h06}
  };

  logic         clk;
  logic [W-1:0] gen, prop;
  logic         cin;
  logic [NB:0]  carry;
  int           n_vec;
  int           n_bad;

  cst_carry_tree u_dut (
    .gen_i   (gen),
    .prop_i  (prop),
    .cin_i   (cin),
    .carry_o (carry)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NB:0] ref_carries(input logic [W-1:0] a,
                                              input logic [W-1:0] b,
                                              input logic c);
    logic [NB:0] r;
    r[0] = c;
    for (int m = 1; m <= NB; m++) begin
      logic [63:0] mask, s;
      mask = (64'd1 << (8*m)) - 64'd1;
      s = ({8'd0, a} & mask) + ({8'd0, b} & mask) + {63'd0, c};
      r[m] = s[8*m];
    end
    return r;
  endfunction

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
    @(posedge clk);
    gen  <= a & b;
    prop <= a ^ b;
    cin  <= c;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [NB:0] act, input logic [NB:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: carry_o=%h expected %h", req, act, exp);
    end
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    gen = '0;
    prop = '0;
    cin = 1'b0;

    // Table walk: hand-computed carries and the reference sum (R1..R7)
    for (int v = 0; v < NVEC; v++) begin
      apply(VECS[v].a, VECS[v].b, VECS[v].cin);
      check("R2 table", carry, VECS[v].exp);
      check("R3 ref", carry, ref_carries(VECS[v].a, VECS[v].b, VECS[v].cin));
    end

    // R1: carry_o[0] tracks cin
    apply(56'h12_3456_789A_BCDE, 56'h0F_0F0F_0F0F_0F0F, 1'b1);
    check("R1", {7'd0, carry[0]}, 8'h01);
    apply(56'h12_3456_789A_BCDE, 56'h0F_0F0F_0F0F_0F0F, 1'b0);
    check("R1", {7'd0, carry[0]}, 8'h00);

    // R4: propagate through two bytes only, then stop
    apply(56'hFFFF, 56'h0, 1'b1);
    check("R4", carry, 8'h07);

    // R5: zero operands with cin set
    apply(56'h0, 56'h0, 1'b1);
    check("R5", {carry[NB:1], 1'b0}, 8'h00);

    // R6: generate at bit 31 only
    apply(56'h8000_0000, 56'h8000_0000, 1'b0);
    check("R6", carry, 8'h10);

    // R7: kill at bit 7 despite a lower carry chain
    apply(56'h7F, 56'h01, 1'b1);
    check("R7", carry, 8'h01);

    // R2/R3: random operands
    for (int r = 0; r < 400; r++) begin
      logic [W-1:0] a, b;
      logic c;
      a = {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;
      b = {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;
      if (r % 4 == 1) b = ~a & 56'hFF_FFFF_FFFF_FFFF;
      c = 1'($urandom);
      apply(a, b, c);
      check("R2 random", carry, ref_carries(a, b, c));
    end

    // R8: change inputs and read in the same cycle, no history
    apply(56'hFF_FFFF_FFFF_FFFF, 56'h1, 1'b0);
    check("R8", carry, 8'hFE);
    apply(56'h0, 56'h0, 1'b0);
    check("R8", carry, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule